// File: doc/BRIEF.md
# Keyed 24-Hour Digital Clock

This block keeps hours, minutes and seconds in a 24-hour day. It receives a one-cycle strobe every 250 microseconds from the system clock domain. A prescaler counts these strobes, and every full count of them advances the seconds by one. Each field is stored as two BCD digits. All six digits leave the block on one bus, ordered hours, minutes, seconds from the most significant end.

Four keys drive a small editor. Each key input is a clean pulse that lasts one cycle. Set chooses the field to edit, up and down step that field, and confirm ends the edit. The seconds keep counting the whole time a field is edited, because the prescaler never stops. When a key press and a natural carry land on the same cycle, the key wins for the field being edited. The carries into the other fields still take effect.

Top module: `keyed_clock24`

## Requirements
- R1: A synchronous active-high reset sets the time to 00:00:00, clears the strobe prescaler and returns the editor to idle (sel_o = 0).
- R2: The seconds advance by one on the cycle that receives the TICKS_PER_SEC-th strobe since the last advance. The default of 4000 strobes makes one second at 250 microseconds per strobe. Cycles without a strobe change nothing.
- R3: The seconds run 00 to 59. The advance after 59 gives 00 and carries one into the minutes.
- R4: The minutes run 00 to 59. A carry arriving at 59 gives 00 and carries one into the hours.
- R5: The hours run 00 to 23. The advance after 23:59:59 gives 00:00:00.
- R6: time_o holds BCD digits. Bits [23:20] and [19:16] are the hours tens and ones, [15:12] and [11:8] the minutes, and [7:4] and [3:0] the seconds.
- R7: sel_o encodes the editor state as 0 idle, 1 hours, 2 minutes, 3 seconds. Set moves 0→1→2→3→1. Confirm returns to 0 and takes precedence over a set press on the same cycle.
- R8: With a field selected, up adds one and down subtracts one, wrapping inside the field's range (59↔00 for minutes and seconds, 23↔00 for hours). Adjustment never carries into a neighbour. Up and down together, or either key in idle, leave the time unchanged.
- R9: Strobes received while editing still count toward the next second, so a second elapses on the same schedule as without editing.
- R10: If an adjustment and an advance or carry reach the same field on the same cycle, the adjustment decides that field. Carries derived from the pre-cycle time still apply to the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle 250 microsecond strobe |
| key_set_i | input | 1 | Field select key pulse |
| key_up_i | input | 1 | Increment key pulse |
| key_down_i | input | 1 | Decrement key pulse |
| key_ok_i | input | 1 | Confirm key pulse |
| time_o | output | 24 | Six BCD digits, hours-minutes-seconds |
| sel_o | output | 2 | Editor state / selected field |

## Verification
The embedded assertions check the following on every cycle:
- the BCD digits stay legal and the hours stay at 23 or below;
- the prescaler stays in range and keeps counting strobes while a field is edited;
- the seconds hold still unless a strobe completes a second or the seconds are being edited;
- confirm always lands in idle;
- idle key presses cannot change the time.

The wrap and carry values, the full midnight rollover and the exact strobe count per second can only be shown by the bench's scenarios. So can every up and down step across each field's whole range and the two same-cycle collisions. The bench compares each of these against an arithmetic model after every cycle.

// File: rtl/keyed_clock24.sv
`timescale 1ns/1ps
module keyed_clock24 #(
  parameter int TICKS_PER_SEC = 4000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        key_set_i,
  input  logic        key_up_i,
  input  logic        key_down_i,
  input  logic        key_ok_i,
  output logic [23:0] time_o,
  output logic [1:0]  sel_o
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_HR = 2'd1, S_MIN = 2'd2, S_SEC = 2'd3;

  logic [PW-1:0] presc;
  logic [7:0]    hr, mn, sc;
  logic [1:0]    sel;

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top, input logic up);
    if (up) begin
      if (v == top) return 8'h00;
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
    end
    if (v == 8'h00) return top;
    if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
    return v - 8'd1;
  endfunction

  wire sec_step = tick_i && (presc == LAST);
  wire sec_wrap = sec_step && (sc == 8'h59);
  wire min_wrap = sec_wrap && (mn == 8'h59);
  wire hr_wrap  = min_wrap && (hr == 8'h23);
  wire adj      = key_up_i ^ key_down_i;

  wire [7:0] sc_n = (sel == S_SEC && adj) ? bcd_step(sc, 8'h59, key_up_i) :
                    sec_step ? bcd_step(sc, 8'h59, 1'b1) : sc;
  wire [7:0] mn_n = (sel == S_MIN && adj) ? bcd_step(mn, 8'h59, key_up_i) :
                    sec_wrap ? bcd_step(mn, 8'h59, 1'b1) : mn;
  wire [7:0] hr_n = (sel == S_HR && adj) ? bcd_step(hr, 8'h23, key_up_i) :
                    hr_wrap ? 8'h00 : min_wrap ? bcd_step(hr, 8'h23, 1'b1) : hr;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc <= '0;
      hr    <= 8'h00;
      mn    <= 8'h00;
      sc    <= 8'h00;
      sel   <= S_IDLE;
    end else begin
      presc <= sec_step ? '0 : (tick_i ? presc + PW'(1) : presc);
      hr    <= hr_n;
      mn    <= mn_n;
      sc    <= sc_n;
      if (key_ok_i)       sel <= S_IDLE;
      else if (key_set_i) sel <= (sel == S_SEC) ? S_HR : sel + 2'd1;
    end
  end

  assign time_o = {hr, mn, sc};
  assign sel_o  = sel;

  // R3
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    sc[3:0] <= 4'd9 && sc <= 8'h59 && mn[3:0] <= 4'd9 && mn <= 8'h59);
  // R5
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    hr[3:0] <= 4'd9 && hr <= 8'h23);
  // R2
  presc_range_chk: assert property (@(posedge clk) disable iff (rst) presc <= LAST);
  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && presc == LAST) && !(sel == S_SEC && (key_up_i ^ key_down_i)) |=> $stable(sc));
  // R9
  presc_edit_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i && presc != LAST && sel != S_IDLE |=> presc == $past(presc) + PW'(1));
  // R7
  confirm_chk: assert property (@(posedge clk) disable iff (rst) key_ok_i |=> sel_o == S_IDLE);
  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    sel == S_IDLE && !(tick_i && presc == LAST) |=> $stable(time_o));
endmodule

// File: tb/keyed_clock24_tb_top.sv
`timescale 1ns/1ps
module keyed_clock24_tb_top;
  localparam int T = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic tick_i = 0, key_set_i = 0, key_up_i = 0, key_down_i = 0, key_ok_i = 0;
  logic [23:0] time_o;
  logic [1:0]  sel_o;
  int checks = 0, errors = 0;
  int h = 0, m = 0, s = 0, pc = 0, sl = 0;

  always #4 clk = ~clk;

  keyed_clock24 #(.TICKS_PER_SEC(T)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .key_set_i(key_set_i), .key_up_i(key_up_i),
    .key_down_i(key_down_i), .key_ok_i(key_ok_i), .time_o(time_o), .sel_o(sel_o));

  function automatic logic [23:0] pack(int hh, int mm, int ss);
    return {4'(hh/10), 4'(hh%10), 4'(mm/10), 4'(mm%10), 4'(ss/10), 4'(ss%10)};
  endfunction

  task automatic chk(input string req);
    logic [23:0] e = pack(h, m, s);
    checks++;
    if (time_o !== e || sel_o !== 2'(sl)) begin
      errors++;
      $display("FAIL %s: time=%h sel=%0d expected time=%h sel=%0d", req, time_o, sel_o, e, sl);
    end
  endtask

  task automatic cyc(input bit tk, input bit st, input bit up, input bit dn, input bit ok, input string req);
    bit stp, sw, mw, ad;
    int d;
    tick_i = tk; key_set_i = st; key_up_i = up; key_down_i = dn; key_ok_i = ok;
    stp = tk && pc == T-1;
    sw = stp && s == 59;
    mw = sw && m == 59;
    ad = (up ^ dn) && sl != 0;
    d = up ? 1 : -1;
    pc = stp ? 0 : (tk ? pc + 1 : pc);
    if (sl == 1 && ad) h = (h + d + 24) % 24; else if (mw) h = (h + 1) % 24;
    if (sl == 2 && ad) m = (m + d + 60) % 60; else if (sw) m = (m + 1) % 60;
    if (sl == 3 && ad) s = (s + d + 60) % 60; else if (stp) s = (s + 1) % 60;
    if (ok) sl = 0; else if (st) sl = (sl == 3) ? 1 : sl + 1;
    @(negedge clk);
    tick_i = 0; key_set_i = 0; key_up_i = 0; key_down_i = 0; key_ok_i = 0;
    chk(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: time=%h sel=%0d expected completion", time_o, sel_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1");
    rst = 0;
    // R2: strobe counting, idle cycles between strobes
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 0, 0, "R2");
      cyc(0, 0, 0, 0, 0, "R2");
    end
    cyc(1, 0, 0, 0, 0, "R2");
    // R8: idle ignores keys
    cyc(0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, "R8");
    // R7: selection walk
    cyc(0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 24; i++) cyc(0, 0, 1, 0, 0, "R8 R6");
    for (int i = 0; i < 24; i++) cyc(0, 0, 0, 1, 0, "R8 R6");
    cyc(0, 0, 1, 1, 0, "R8");
    cyc(0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, 0, 0, "R8 R6");
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 0, "R8 R6");
    cyc(0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, 0, 0, "R8 R6");
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 0, "R8 R6");
    cyc(0, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 1, "R7");
    // preset 23:58:50 through the keys
    cyc(0, 1, 0, 0, 0, "R7");
    while (h != 23) cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 1, 0, 0, 0, "R7");
    while (m != 58) cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 1, 0, 0, 0, "R7");
    while (s != 50) cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R7");
    // R3 R4 R5: run across the midnight rollover
    for (int i = 0; i < 100 * T; i++) begin
      cyc(1, 0, 0, 0, 0, "R3 R4 R5");
      cyc(0, 0, 0, 0, 0, "R3 R4 R5");
    end
    // R9: strobes keep counting while editing seconds
    cyc(0, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < T; i++) begin
      cyc(1, 0, 0, 0, 0, "R9");
      cyc(0, 0, 1, 0, 0, "R9");
    end
    // R10: seconds collision
    while (pc != T-1) cyc(1, 0, 0, 0, 0, "R9");
    while (s != 59) cyc(0, 0, 1, 0, 0, "R8");
    cyc(1, 0, 0, 1, 0, "R10");
    // R10: minutes collision
    while (s != 59) cyc(0, 0, 1, 0, 0, "R8");
    cyc(0, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, "R7");
    while (m != 59) cyc(0, 0, 1, 0, 0, "R8");
    while (pc != T-1) cyc(1, 0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 1, 0, "R10");
    cyc(0, 0, 0, 0, 1, "R7");
    rst = 1;
    @(negedge clk);
    h = 0; m = 0; s = 0; pc = 0; sl = 0;
    chk("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule